// File: doc/BRIEF.md
# Audio sample FIFO with channel conversion

This block sits on the playback path between a parallel audio sample stream and a serial audio port. Samples arrive one word per accepted valid/ready transfer and are stored interleaved in a FIFO. On the way into storage the block can fold a stereo pair into one mono word or expand a mono sample into a stereo pair. Samples are right-aligned and the block keeps only the low bits for the configured sample width.

The serializer side asks for one sample per channel slot with a request pulse and receives it one cycle later. Nothing is released until the number of whole stored frames exceeds a programmable start threshold. From then on samples flow until the FIFO runs dry, and the block then waits for the threshold again. The threshold is counted in frames of the configured channel count and is clamped to what the FIFO can hold. Each instance carries its own conversion settings, so a playback instance and a capture instance are configured independently.

Top module: `pcm_frame_fifo`

## Requirements
- R1: After reset `in_ready` is 1, and `out_valid`, `underflow` and `streaming` are 0.
- R2: `streaming` rises once the stored word count reaches (T+1)*C, meaning more than T whole frames, where C is the effective channel count and T is the effective threshold. While `streaming` is 0, a request with data stored gives neither `out_valid` nor `underflow`, and the stored words stay in place.
- R3: The effective threshold is min(`cfg_thresh`, floor(DEPTH/C) - 1).
- R4: While `streaming` is 1, a request makes `out_valid` 1 on the next cycle, with the oldest stored word on `out_data`. `streaming` falls after the FIFO empties.
- R5: A request while the FIFO is empty makes `underflow` 1 for one cycle on the next cycle, with `out_valid` 0.
- R6: `in_ready` is 0 while DEPTH words are stored, and while the second word of an upmix is still pending.
- R7: `cfg_width` code 0 selects 8-bit samples, 1 selects 16-bit, and 2 or 3 selects 32-bit. Every stored word keeps the low bits of the selected width and has its upper bits zero.
- R8: `cfg_conv` code 1 selects downmix. Consecutive inputs form a pair, channel 0 first. `cfg_down` code 0 stores channel 0, code 1 stores channel 1, and code 3 stores channel 0.
- R9: `cfg_down` code 2 stores the floor average of the two signed samples, computed with one extra bit of headroom, so 0x8000 with 0x8000 gives 0x8000 and 0xFFFF with 0x0000 gives 0xFFFF at 16 bits.
- R10: `cfg_conv` code 2 selects upmix. Each input is stored as itself, then a second word follows: zero when `cfg_up` is 0, a copy when `cfg_up` is 1. `cfg_conv` code 0 or 3 stores inputs unchanged.
- R11: The legal channel counts are 1 to MAX_CH. A `cfg_chans` value of 0 or above MAX_CH is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_chans | input | 5 | Channels per frame as stored |
| cfg_width | input | 2 | Sample width code |
| cfg_thresh | input | 6 | Start threshold in frames |
| cfg_conv | input | 2 | Conversion select: pass, downmix, upmix |
| cfg_down | input | 2 | Downmix mode |
| cfg_up | input | 1 | Upmix fill: 0 zero, 1 copy |
| in_valid | input | 1 | Upstream sample valid |
| in_data | input | 32 | Upstream sample, right-aligned |
| in_ready | output | 1 | Block accepts a sample this cycle |
| out_req | input | 1 | Serializer asks for the next slot sample |
| out_valid | output | 1 | Sample on out_data answers last cycle's request |
| out_data | output | 32 | Delivered sample |
| underflow | output | 1 | Request arrived while the FIFO was empty |
| streaming | output | 1 | Start threshold met; requests are served |

## Verification
An accepted input word is counted in storage at the edge that accepts it. The second word of an upmix is counted one edge later, and `streaming` follows the count one edge after that. The bench therefore waits three cycles after the last input before it judges `streaming`. Request answers, both `out_valid` with data and `underflow`, are due exactly one edge after the request. The bench raises `out_req` on a falling edge and reads the outputs on the next falling edge. The drop of `streaming` after draining is checked after the same three-cycle settle.

// File: rtl/pcmf_pkg.sv
package pcmf_pkg;

    localparam int SMP_W = 32;

    typedef enum logic [1:0] {
        CONV_PASS = 2'd0,
        CONV_DOWN = 2'd1,
        CONV_UP   = 2'd2
    } conv_e;

    typedef enum logic [1:0] {
        DSEL_CH0 = 2'd0,
        DSEL_CH1 = 2'd1,
        DSEL_AVG = 2'd2
    } dsel_e;

    // write-side converter state
    typedef struct packed {
        logic [SMP_W-1:0] hold;
        logic             have;
        logic             pend;
        logic [SMP_W-1:0] pend_data;
    } conv_st_t;

    // delivery register state
    typedef struct packed {
        logic             ov;
        logic [SMP_W-1:0] od;
        logic             uf;
    } outp_st_t;

    function automatic logic [SMP_W-1:0] wmask(input logic [1:0] wc);
        case (wc)
            2'd0:    wmask = SMP_W'(32'h0000_00FF);
            2'd1:    wmask = SMP_W'(32'h0000_FFFF);
            default: wmask = '1;
        endcase
    endfunction

    function automatic logic signed [SMP_W:0] sext(input logic [SMP_W-1:0] d,
                                                   input logic [1:0] wc);
        case (wc)
            2'd0:    sext = {{(SMP_W-7){d[7]}}, d[7:0]};
            2'd1:    sext = {{(SMP_W-15){d[15]}}, d[15:0]};
            default: sext = {d[SMP_W-1], d};
        endcase
    endfunction

    function automatic logic [SMP_W-1:0] mix_avg(input logic [SMP_W-1:0] a,
                                                 input logic [SMP_W-1:0] b,
                                                 input logic [1:0] wc);
        logic signed [SMP_W:0] s;
        s = sext(a, wc) + sext(b, wc);
        s = s >>> 1;
        mix_avg = s[SMP_W-1:0] & wmask(wc);
    endfunction

endpackage

// File: rtl/pcmf_conv.sv
module pcmf_conv
    import pcmf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       conv,
    input  logic [1:0]       down_sel,
    input  logic             up_copy,
    input  logic [1:0]       width,
    input  logic             in_valid,
    input  logic [SMP_W-1:0] in_data,
    input  logic             full,
    output logic             in_ready,
    output logic             wr_en,
    output logic [SMP_W-1:0] wr_data
);

    conv_st_t st_d, st_q;
    logic             rdy;
    logic             acc;
    logic [SMP_W-1:0] smp;

    always_comb begin
        st_d    = st_q;
        wr_en   = 1'b0;
        wr_data = '0;
        rdy     = !st_q.pend && !full;
        acc     = in_valid && rdy;
        smp     = in_data & wmask(width);

        if (st_q.pend) begin
            // second word of an upmix goes in before anything new
            if (!full) begin
                wr_en     = 1'b1;
                wr_data   = st_q.pend_data;
                st_d.pend = 1'b0;
            end
        end else if (acc) begin
            case (conv)
                CONV_DOWN: begin
                    if (!st_q.have) begin
                        st_d.hold = smp;
                        st_d.have = 1'b1;
                    end else begin
                        wr_en     = 1'b1;
                        st_d.have = 1'b0;
                        case (down_sel)
                            DSEL_CH1: wr_data = smp;
                            DSEL_AVG: wr_data = mix_avg(st_q.hold, smp, width);
                            default:  wr_data = st_q.hold;
                        endcase
                    end
                end
                CONV_UP: begin
                    wr_en          = 1'b1;
                    wr_data        = smp;
                    st_d.pend      = 1'b1;
                    st_d.pend_data = up_copy ? smp : '0;
                end
                default: begin
                    wr_en   = 1'b1;
                    wr_data = smp;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_ready = rdy;

endmodule

// File: rtl/pcmf_store.sv
module pcmf_store #(
    parameter int DEPTH  = 64,
    parameter int W      = 32,
    localparam int AW     = $clog2(DEPTH),
    localparam int FILL_W = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [W-1:0]      wr_data,
    input  logic              rd_en,
    output logic [W-1:0]      rd_data,
    output logic [FILL_W-1:0] fill,
    output logic              full,
    output logic              empty
);

    typedef struct packed {
        logic [AW-1:0]     wp;
        logic [AW-1:0]     rp;
        logic [FILL_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic do_wr, do_rd;

    always_comb begin
        st_d  = st_q;
        do_wr = wr_en && (st_q.cnt != FILL_W'(DEPTH));
        do_rd = rd_en && (st_q.cnt != '0);
        if (do_wr) st_d.wp = st_q.wp + 1'b1;
        if (do_rd) st_d.rp = st_q.rp + 1'b1;
        case ({do_wr, do_rd})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[st_q.wp] <= wr_data;
    end

    assign rd_data = mem[st_q.rp];
    assign fill    = st_q.cnt;
    assign full    = (st_q.cnt == FILL_W'(DEPTH));
    assign empty   = (st_q.cnt == '0);

endmodule

// File: rtl/pcmf_gate.sv
module pcmf_gate #(
    parameter int DEPTH  = 64,
    parameter int MAX_CH = 16,
    localparam int CH_W   = $clog2(MAX_CH + 1),
    localparam int TH_W   = $clog2(DEPTH),
    localparam int FILL_W = TH_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CH_W-1:0]   chans,
    input  logic [TH_W-1:0]   thresh,
    input  logic [FILL_W-1:0] fill,
    output logic              run
);

    typedef struct packed {
        logic run;
    } st_t;

    st_t st_d, st_q;
    logic [CH_W-1:0]   eff_ch;
    logic [TH_W-1:0]   lim;
    logic [TH_W-1:0]   t_eff;
    logic [FILL_W-1:0] need;

    always_comb begin
        eff_ch = (chans == '0 || int'(chans) > MAX_CH) ? CH_W'(1) : chans;
        // largest legal frame threshold for the active channel count
        lim = TH_W'(DEPTH - 1);
        for (int c = 1; c <= MAX_CH; c++) begin
            if (eff_ch == CH_W'(c)) lim = TH_W'(DEPTH / c - 1);
        end
        t_eff = (thresh > lim) ? lim : thresh;
        need  = FILL_W'((int'(t_eff) + 1) * int'(eff_ch));

        st_d = st_q;
        if (st_q.run) st_d.run = (fill != '0);
        else          st_d.run = (fill >= need);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run = st_q.run;

endmodule

// File: rtl/pcm_frame_fifo.sv
module pcm_frame_fifo
    import pcmf_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int MAX_CH = 16,
    localparam int CH_W   = $clog2(MAX_CH + 1),
    localparam int TH_W   = $clog2(DEPTH),
    localparam int FILL_W = TH_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CH_W-1:0]  cfg_chans,
    input  logic [1:0]       cfg_width,
    input  logic [TH_W-1:0]  cfg_thresh,
    input  logic [1:0]       cfg_conv,
    input  logic [1:0]       cfg_down,
    input  logic             cfg_up,
    input  logic             in_valid,
    input  logic [SMP_W-1:0] in_data,
    output logic             in_ready,
    input  logic             out_req,
    output logic             out_valid,
    output logic [SMP_W-1:0] out_data,
    output logic             underflow,
    output logic             streaming
);

    logic              wr_en;
    logic [SMP_W-1:0]  wr_data;
    logic              rd_en;
    logic [SMP_W-1:0]  rd_data;
    logic [FILL_W-1:0] fill_w;
    logic              full_w;
    logic              empty_w;
    logic              run_w;

    pcmf_conv u_conv (
        .clk      (clk),
        .rst_n    (rst_n),
        .conv     (cfg_conv),
        .down_sel (cfg_down),
        .up_copy  (cfg_up),
        .width    (cfg_width),
        .in_valid (in_valid),
        .in_data  (in_data),
        .full     (full_w),
        .in_ready (in_ready),
        .wr_en    (wr_en),
        .wr_data  (wr_data)
    );

    pcmf_store #(.DEPTH(DEPTH), .W(SMP_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .fill    (fill_w),
        .full    (full_w),
        .empty   (empty_w)
    );

    pcmf_gate #(.DEPTH(DEPTH), .MAX_CH(MAX_CH)) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .chans  (cfg_chans),
        .thresh (cfg_thresh),
        .fill   (fill_w),
        .run    (run_w)
    );

    outp_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        rd_en = out_req && run_w && !empty_w;
        st_d.ov = rd_en;
        st_d.uf = out_req && empty_w;
        if (rd_en) st_d.od = rd_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.ov;
    assign out_data  = st_q.od;
    assign underflow = st_q.uf;
    assign streaming = run_w;

endmodule

// File: rtl/pcmf_checker.sv
module pcmf_checker #(
    parameter int DEPTH = 64,
    localparam int FILL_W = $clog2(DEPTH) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              out_req,
    input logic              out_valid,
    input logic              underflow,
    input logic              streaming,
    input logic [FILL_W-1:0] fill
);

    a_r5_uf_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && underflow));

    a_r4_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(out_req) && $past(streaming)));

    a_r5_uf_only_empty: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> ($past(fill) == '0));

    a_r6_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == FILL_W'(DEPTH)) |-> !in_ready);

    a_r6_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FILL_W'(DEPTH));

    a_r2_start_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(streaming) |-> ($past(fill) != '0));

endmodule

bind pcm_frame_fifo pcmf_checker #(.DEPTH(DEPTH)) u_pcmf_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_req   (out_req),
    .out_valid (out_valid),
    .underflow (underflow),
    .streaming (streaming),
    .fill      (fill_w)
);

// File: tb/test_pcm_frame_fifo.sv
module test_pcm_frame_fifo;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;
    localparam int MAX_CH     = 16;
    localparam int WD_LIMIT   = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  cfg_chans;
    logic [1:0]  cfg_width;
    logic [5:0]  cfg_thresh;
    logic [1:0]  cfg_conv;
    logic [1:0]  cfg_down;
    logic        cfg_up;
    logic        in_valid;
    logic [31:0] in_data;
    logic        in_ready;
    logic        out_req;
    logic        out_valid;
    logic [31:0] out_data;
    logic        underflow;
    logic        streaming;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    logic [31:0] expq[$];

    pcm_frame_fifo #(.DEPTH(DEPTH), .MAX_CH(MAX_CH)) i_pcm_frame_fifo (
        .clk(clk), .rst_n(rst_n), .cfg_chans(cfg_chans), .cfg_width(cfg_width),
        .cfg_thresh(cfg_thresh), .cfg_conv(cfg_conv), .cfg_down(cfg_down),
        .cfg_up(cfg_up), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_req(out_req), .out_valid(out_valid),
        .out_data(out_data), .underflow(underflow), .streaming(streaming)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cyc, WD_LIMIT);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic logic [31:0] msk(input int w);
        case (w)
            0:       return 32'h0000_00FF;
            1:       return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic longint sgn(input logic [31:0] d, input int w);
        case (w)
            0:       return longint'($signed(d[7:0]));
            1:       return longint'($signed(d[15:0]));
            default: return longint'($signed(d));
        endcase
    endfunction

    function automatic logic [31:0] avg_ref(input logic [31:0] a, input logic [31:0] b, input int w);
        longint s;
        s = (sgn(a, w) + sgn(b, w)) >>> 1;
        return s[31:0] & msk(w);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_data  = '0;
        out_req  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic push(input logic [31:0] d);
        in_valid = 1'b1;
        in_data  = d;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pull(output logic v, output logic [31:0] d, output logic u);
        out_req = 1'b1;
        @(negedge clk);
        out_req = 1'b0;
        v = out_valid;
        d = out_data;
        u = underflow;
    endtask

    // kind: 0 pass, 1 down ch0, 2 down ch1, 3 down avg, 4 up zero, 5 up copy
    task automatic push_unit(input int kind, input int w, input logic [31:0] a, input logic [31:0] b);
        case (kind)
            0: begin push(a); expq.push_back(a & msk(w)); end
            1, 2, 3: begin
                push(a); push(b);
                if (kind == 1)      expq.push_back(a & msk(w));
                else if (kind == 2) expq.push_back(b & msk(w));
                else                expq.push_back(avg_ref(a, b, w));
            end
            default: begin
                push(a);
                expq.push_back(a & msk(w));
                expq.push_back(kind == 5 ? (a & msk(w)) : 32'h0);
            end
        endcase
    endtask

    task automatic set_cfg(input int kind, input int w, input int ch, input int th);
        cfg_width  = 2'(w);
        cfg_chans  = 5'(ch);
        cfg_thresh = 6'(th);
        cfg_conv   = (kind == 0) ? 2'd0 : (kind <= 3) ? 2'd1 : 2'd2;
        cfg_down   = (kind >= 1 && kind <= 3) ? 2'(kind - 1) : 2'd0;
        cfg_up     = (kind == 5);
    endtask

    task automatic drain(input string tag);
        logic v, u;
        logic [31:0] d;
        while (expq.size() > 0) begin
            pull(v, d, u);
            chk({tag, " R4 out_valid on request"}, {31'b0, v}, 32'd1);
            chk({tag, " data order"}, d, expq.pop_front());
        end
    endtask

    task automatic round(input string tag, input int kind, input int w, input int ch, input int th);
        int eff, lim, te, need, units;
        logic v, u;
        logic [31:0] d;
        set_cfg(kind, w, ch, th);
        do_reset();
        expq.delete();
        eff   = (ch < 1 || ch > MAX_CH) ? 1 : ch;
        lim   = DEPTH / eff - 1;
        te    = (th > lim) ? lim : th;
        need  = (te + 1) * eff;
        units = (kind >= 4) ? need / 2 : need;
        for (int i = 0; i < units - 1; i++) push_unit(kind, w, $urandom, $urandom);
        repeat (3) @(negedge clk);
        chk({tag, " R2 idle below threshold"}, {31'b0, streaming}, 32'd0);
        if (expq.size() > 0) begin
            pull(v, d, u);
            chk({tag, " R2 request ignored valid"}, {31'b0, v}, 32'd0);
            chk({tag, " R2 request ignored underflow"}, {31'b0, u}, 32'd0);
        end
        push_unit(kind, w, $urandom, $urandom);
        repeat (3) @(negedge clk);
        chk({tag, " R2 R3 streaming at threshold"}, {31'b0, streaming}, 32'd1);
        if (need == DEPTH) chk({tag, " R6 in_ready low when full"}, {31'b0, in_ready}, 32'd0);
        drain(tag);
        repeat (3) @(negedge clk);
        chk({tag, " R4 streaming drops when empty"}, {31'b0, streaming}, 32'd0);
        pull(v, d, u);
        chk({tag, " R5 underflow on empty"}, {31'b0, u}, 32'd1);
        chk({tag, " R5 no valid on empty"}, {31'b0, v}, 32'd0);
    endtask

    initial begin
        int seed_init;
        logic v, u;
        logic [31:0] d;
        seed_init = $urandom(32'd20240611);

        // R1: reset state
        set_cfg(0, 2, 2, 0);
        do_reset();
        chk("R1 in_ready", {31'b0, in_ready}, 32'd1);
        chk("R1 out_valid", {31'b0, out_valid}, 32'd0);
        chk("R1 underflow", {31'b0, underflow}, 32'd0);
        chk("R1 streaming", {31'b0, streaming}, 32'd0);

        // directed: threshold, clamp, full FIFO, channel range
        round("R2 stereo T3", 0, 2, 2, 3);
        round("R3 clamp three ch", 0, 2, 3, 63);
        round("R3 R6 clamp full", 0, 1, 16, 5);
        round("R11 zero chans", 0, 2, 0, 4);
        round("R11 over range chans", 0, 2, 20, 2);

        // R7: width masking
        set_cfg(0, 0, 1, 0);
        do_reset();
        push(32'h1234_56AB);
        repeat (3) @(negedge clk);
        pull(v, d, u);
        chk("R7 8-bit keeps low byte", d, 32'h0000_00AB);
        cfg_width = 2'd3;
        do_reset();
        push(32'hDEAD_BEEF);
        repeat (3) @(negedge clk);
        pull(v, d, u);
        chk("R7 code 3 is 32-bit", d, 32'hDEAD_BEEF);

        // R9: average corners at 16 bits
        set_cfg(3, 1, 1, 0);
        do_reset();
        push(32'h8000); push(32'h8000);
        push(32'h7FFF); push(32'h0001);
        push(32'hFFFF); push(32'h0000);
        push(32'h0003); push(32'h0000);
        repeat (3) @(negedge clk);
        pull(v, d, u); chk("R9 min plus min", d, 32'h8000);
        pull(v, d, u); chk("R9 max plus one", d, 32'h4000);
        pull(v, d, u); chk("R9 minus one floors", d, 32'hFFFF);
        pull(v, d, u); chk("R9 three halves", d, 32'h0001);

        // R8: select code 3 behaves as channel 0
        set_cfg(1, 2, 1, 0);
        cfg_down = 2'd3;
        do_reset();
        push(32'h1111_1111); push(32'h2222_2222);
        repeat (3) @(negedge clk);
        pull(v, d, u);
        chk("R8 select code 3 keeps ch0", d, 32'h1111_1111);

        // R10: upmix ordering, and pass code 3
        set_cfg(5, 0, 2, 0);
        do_reset();
        push(32'h0000_0042);
        repeat (3) @(negedge clk);
        pull(v, d, u); chk("R10 copy first", d, 32'h42);
        pull(v, d, u); chk("R10 copy second", d, 32'h42);
        round("R10 zero fill", 4, 1, 2, 1);
        set_cfg(0, 2, 1, 0);
        cfg_conv = 2'd3;
        do_reset();
        push(32'hCAFE_F00D);
        repeat (3) @(negedge clk);
        pull(v, d, u);
        chk("R10 conv code 3 passes", d, 32'hCAFE_F00D);

        // random rounds over all modes
        for (int r = 0; r < 30; r++) begin
            int kind, w, ch, th;
            kind = $urandom % 6;
            w    = $urandom % 3;
            th   = $urandom % 64;
            ch   = (kind == 0) ? 1 + ($urandom % 16) : (kind <= 3) ? 1 : 2;
            case (kind)
                0:       round("R2 R4 rand pass", kind, w, ch, th);
                1, 2:    round("R8 rand down", kind, w, ch, th);
                3:       round("R9 rand avg", kind, w, ch, th);
                default: round("R10 rand up", kind, w, ch, th);
            endcase
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule